// File: doc/BRIEF.md
# Two-Output PWM Generator with Buffered Timing and Cross-Conduction Guard

This block produces a pair of pulse-width-modulated outputs, A and B, from one free-running 12-bit cycle counter. Each output has a compare value that drives it high and a compare value that drives it low. The counter runs from zero up to a programmable period and then wraps to zero. The wrap marks the end of a PWM cycle.

Software writes timing and output settings into a buffer through a simple write port. While the cycle is running, those writes have no effect on it. At the wrap, if the hold bit is clear, the whole buffer becomes the working set in one step. While the hold bit is set, nothing moves across. This lets a complete new set of values be staged over many writes and then applied as one unit.

A guard keeps the two outputs from being high together, because in a half-bridge that would short the supply. The guard favours whichever output was already on. It is active by default and can be turned off with a configuration bit.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: `cnt` counts up by one per clock from 0 to the working period value. On the clock after it equals the period it reads 0.
- R2: An output's internal request goes high on the clock edge where `cnt` equals that output's set value, and low on the edge where `cnt` equals its clear value. If the two values are equal, set wins. The pin follows the request one clock later, so the pin rises when `cnt` reads set+2.
- R3: A write to any buffered register (addresses 1 to 6) leaves the working set unchanged except at the end-of-cycle edge.
- R4: While the hold bit (address 0, bit 0, which takes effect on the next edge) is 1, the working set does not change at the end of a cycle.
- R5: While the hold bit is 0, the whole buffer is copied into the working set on the clock edge where `cnt` equals the working period.
- R6: The buffered set is: output configuration (address 1), period (address 2), A set (address 3), A clear (address 4), B set (address 5), B clear (address 6). A write uses the low 12 bits of `wr_data`.
- R7: While the guard is active, `pwm_a` and `pwm_b` are never 1 in the same cycle. The guard is active when configuration bit 2 was 0 on the previous cycle.
- R8: Under the guard, when both outputs request, the output that was already high stays high and the other is held low until the first one drops. If neither was high, A wins.
- R9: With configuration bit 2 set to 1 the guard is off, and both outputs may be high together.
- R10: An output whose enable is 0 is driven low. Configuration bit 0 enables A and bit 1 enables B.
- R11: After reset, `cnt`, both outputs, the hold bit, the buffer and the working set are all zero. The guard is therefore active and both outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| cnt | output | 12 | Current cycle counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The hardest case to reach is the guard having to choose: both requests must be high in the same cycle, with a known output already owning the pair. The stimulus stages overlapping compare windows under hold and then releases the hold. This applies the whole set at one wrap, so the first full cycle afterwards starts from a known owner. A second staging makes both set values equal, so that both requests rise together. A reference model in the bench follows every register write and every wrap. It compares the counter and both outputs on every clock, including the cycles around each transfer.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int CNT_W  = 12;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_HOLD   = 3'd0,
        ADR_OUTCFG = 3'd1,
        ADR_PERIOD = 3'd2,
        ADR_SET_A  = 3'd3,
        ADR_CLR_A  = 3'd4,
        ADR_SET_B  = 3'd5,
        ADR_CLR_B  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic             guard_off;
        logic             en_b;
        logic             en_a;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] set_a;
        logic [CNT_W-1:0] clr_a;
        logic [CNT_W-1:0] set_b;
        logic [CNT_W-1:0] clr_b;
    } timing_set_t;

    localparam timing_set_t TIMING_RESET = '0;

    // Next request state for one output given the counter and its compares.
    function automatic logic next_request(input logic             cur,
                                          input logic [CNT_W-1:0] count,
                                          input logic [CNT_W-1:0] set_v,
                                          input logic [CNT_W-1:0] clr_v);
        if (count == set_v)      return 1'b1;
        else if (count == clr_v) return 1'b0;
        else                     return cur;
    endfunction

endpackage

// File: rtl/pwm_timing_regs.sv
module pwm_timing_regs
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cycle_end,
    output timing_set_t       work_set,
    output logic              hold
);

    timing_set_t buf_q;
    timing_set_t work_q;
    logic        hold_q;
    reg_addr_e   addr;

    assign addr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= TIMING_RESET;
            hold_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADR_HOLD:   hold_q        <= wr_data[0];
                ADR_OUTCFG: begin
                    buf_q.en_a      <= wr_data[0];
                    buf_q.en_b      <= wr_data[1];
                    buf_q.guard_off <= wr_data[2];
                end
                ADR_PERIOD: buf_q.period <= wr_data;
                ADR_SET_A:  buf_q.set_a  <= wr_data;
                ADR_CLR_A:  buf_q.clr_a  <= wr_data;
                ADR_SET_B:  buf_q.set_b  <= wr_data;
                ADR_CLR_B:  buf_q.clr_b  <= wr_data;
                default:    ;
            endcase
        end
    end

    // Atomic transfer of the whole buffer at the cycle boundary.
    always_ff @(posedge clk) begin
        if (rst)
            work_q <= TIMING_RESET;
        else if (cycle_end && !hold_q)
            work_q <= buf_q;
    end

    assign work_set = work_q;
    assign hold     = hold_q;

endmodule

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             cycle_end
);

    logic [CNT_W-1:0] count_q;

    assign cycle_end = (count_q >= period);

    always_ff @(posedge clk) begin
        if (rst)            count_q <= '0;
        else if (cycle_end) count_q <= '0;
        else                count_q <= count_q + 1'b1;
    end

    assign count = count_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] set_v,
    input  logic [CNT_W-1:0] clr_v,
    input  logic             enable,
    output logic             request
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= next_request(req_q, count, set_v, clr_v);
    end

    assign request = req_q & enable;

endmodule

// File: rtl/pwm_overlap_guard.sv
module pwm_overlap_guard (
    input  logic clk,
    input  logic rst,
    input  logic guard_on,
    input  logic req_a,
    input  logic req_b,
    output logic out_a,
    output logic out_b
);

    logic q_a, q_b;
    logic conflict;
    logic b_owns;
    logic grant_a, grant_b;

    assign conflict = guard_on && req_a && req_b;
    assign b_owns   = q_b && !q_a;
    assign grant_a  = req_a && !(conflict && b_owns);
    assign grant_b  = req_b && !(conflict && !b_owns);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= 1'b0;
            q_b <= 1'b0;
        end else begin
            q_a <= grant_a;
            q_b <= grant_b;
        end
    end

    assign out_a = q_a;
    assign out_b = q_b;

endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              pwm_a,
    output logic              pwm_b
);

    timing_set_t      act_cfg;
    logic             lock_q;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] set_v [NUM_CH];
    logic [CNT_W-1:0] clr_v [NUM_CH];
    logic             en_v  [NUM_CH];
    logic             req_v [NUM_CH];

    pwm_timing_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cycle_end (wrap),
        .work_set  (act_cfg),
        .hold      (lock_q)
    );

    pwm_cycle_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .period    (act_cfg.period),
        .count     (count),
        .cycle_end (wrap)
    );

    assign set_v[0] = act_cfg.set_a;
    assign clr_v[0] = act_cfg.clr_a;
    assign en_v[0]  = act_cfg.en_a;
    assign set_v[1] = act_cfg.set_b;
    assign clr_v[1] = act_cfg.clr_b;
    assign en_v[1]  = act_cfg.en_b;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .count   (count),
            .set_v   (set_v[g]),
            .clr_v   (clr_v[g]),
            .enable  (en_v[g]),
            .request (req_v[g])
        );
    end

    pwm_overlap_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .guard_on (!act_cfg.guard_off),
        .req_a    (req_v[0]),
        .req_b    (req_v[1]),
        .out_a    (pwm_a),
        .out_b    (pwm_b)
    );

    assign cnt = count;

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             pwm_a,
    input logic             pwm_b,
    input timing_set_t      act,
    input logic             lock
);

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (cnt < act.period) |=> (cnt == $past(cnt) + 12'd1));

    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == act.period) |=> (cnt == '0));

    a_r3_midcycle_stable: assert property (@(posedge clk) disable iff (rst)
        (cnt < act.period) |=> $stable(act));

    a_r4_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (lock && cnt == act.period) |=> $stable(act));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !$past(act.guard_off) |-> !(pwm_a && pwm_b));

    a_r10_a_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !$past(act.en_a) |-> !pwm_a);

    a_r10_b_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !$past(act.en_b) |-> !pwm_b);

endmodule

bind pwm_pair_ctrl pwm_pair_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt),
    .pwm_a (pwm_a),
    .pwm_b (pwm_b),
    .act   (act_cfg),
    .lock  (lock_q)
);

// File: tb/pwm_pair_ctrl_tb.sv
module pwm_pair_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [11:0] cnt;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R11";

    always #10 clk = ~clk;

    pwm_pair_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt(cnt), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Reference model state: index 0..6 by register address (0 unused in sh/wk)
    int sh [7];
    int wk [7];
    int m_hold, m_cnt, m_ra, m_rb, m_oa, m_ob;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 7; i++) begin sh[i] = 0; wk[i] = 0; end
            m_hold = 0; m_cnt = 0; m_ra = 0; m_rb = 0; m_oa = 0; m_ob = 0;
        end else begin
            int ea, eb, prot, wa, wb, na, nb, wrapped;
            ea = wk[1] & 1; eb = (wk[1] >> 1) & 1; prot = ((wk[1] >> 2) & 1) == 0;
            wa = m_ra & ea; wb = m_rb & eb;
            na = wa; nb = wb;
            if (prot && wa && wb) begin
                if (m_ob == 1 && m_oa == 0) na = 0; else nb = 0;
            end
            if (m_cnt == wk[3]) m_ra = 1; else if (m_cnt == wk[4]) m_ra = 0;
            if (m_cnt == wk[5]) m_rb = 1; else if (m_cnt == wk[6]) m_rb = 0;
            m_oa = na; m_ob = nb;
            wrapped = (m_cnt >= wk[2]);
            m_cnt = wrapped ? 0 : m_cnt + 1;
            if (wrapped && m_hold == 0)
                for (int i = 1; i < 7; i++) wk[i] = sh[i];
            if (wr_en) begin
                if (wr_addr == 0) m_hold = wr_data[0];
                else if (wr_addr == 1) sh[1] = wr_data[2:0];
                else if (wr_addr < 7) sh[wr_addr] = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            checks++;
            if (cnt != m_cnt[11:0] || pwm_a != m_oa[0] || pwm_b != m_ob[0]) begin
                errors++;
                $display("FAIL %s cycle model: actual cnt=%0d a=%0b b=%0b expected cnt=%0d a=%0d b=%0d",
                         tag, cnt, pwm_a, pwm_b, m_cnt, m_oa, m_ob);
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[11:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (cnt != v[11:0]);
    endtask

    task automatic stage(input int cfg, input int per, input int sa, input int ca,
                         input int sb, input int cb);
        wr(0, 1);
        wr(1, cfg); wr(2, per); wr(3, sa); wr(4, ca); wr(5, sb); wr(6, cb);
        wr(0, 0);
        wait_cnt(0);
        wait_cnt(0);
    endtask

    initial begin
        int mx, both, bhigh;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(cnt == 0, "R11 cnt after reset", cnt, 0);
        check(pwm_a == 0 && pwm_b == 0, "R11 outputs after reset", {pwm_a, pwm_b}, 0);
        rst = 1'b0;

        // R4: hold set, staged values must not reach the working set
        tag = "R4";
        wr(0, 1);
        wr(1, 3); wr(2, 9); wr(3, 1); wr(4, 4); wr(5, 6); wr(6, 8);
        mx = 0;
        repeat (8) begin @(negedge clk); if (cnt > mx) mx = cnt; end
        check(mx == 0, "R4 period held back", mx, 0);

        // R5/R6: release hold, whole set applied at the wrap
        tag = "R5";
        wr(0, 0);
        wait_cnt(0); wait_cnt(0);
        mx = 0;
        repeat (20) begin @(negedge clk); if (cnt > mx) mx = cnt; end
        check(mx == 9, "R5 new period in effect", mx, 9);

        // R2: A high for cnt 3..5, low from 6
        tag = "R2";
        wait_cnt(3); check(pwm_a == 1, "R2 A high at set+2", pwm_a, 1);
        wait_cnt(6); check(pwm_a == 0, "R2 A low at clear+2", pwm_a, 0);
        wait_cnt(8); check(pwm_b == 1, "R2 B high at set+2", pwm_b, 1);

        // R3: mid-cycle write without hold changes nothing until the wrap
        tag = "R3";
        wait_cnt(1);
        wr(3, 0);
        wait_cnt(3); check(pwm_a == 1, "R3 running cycle kept old set", pwm_a, 1);
        wait_cnt(0);
        wait_cnt(2); check(pwm_a == 1, "R3 new set after wrap", pwm_a, 1);

        // R8: A owns, B overlaps and is held back
        tag = "R8";
        stage(3, 9, 1, 4, 2, 7);
        wait_cnt(5); check(pwm_b == 0, "R8 B held while A owns", pwm_b, 0);
        wait_cnt(6); check(pwm_b == 1, "R8 B after A drops", pwm_b, 1);
        tag = "R7";
        both = 0;
        repeat (30) begin @(negedge clk); if (pwm_a && pwm_b) both++; end
        check(both == 0, "R7 never both high", both, 0);

        // R8: simultaneous request, A wins
        tag = "R8";
        stage(3, 9, 1, 4, 1, 7);
        wait_cnt(3);
        check(pwm_a == 1 && pwm_b == 0, "R8 tie goes to A", {pwm_a, pwm_b}, 2);

        // R9: guard off lets both be high
        tag = "R9";
        stage(7, 9, 1, 6, 2, 8);
        both = 0;
        repeat (30) begin @(negedge clk); if (pwm_a && pwm_b) both++; end
        check(both > 0, "R9 overlap allowed with guard off", both, 1);

        // R10: only A enabled, guard still on
        tag = "R10";
        stage(1, 9, 1, 6, 2, 8);
        bhigh = 0;
        repeat (30) begin @(negedge clk); if (pwm_b) bhigh++; end
        check(bhigh == 0, "R10 disabled B stays low", bhigh, 0);

        // R6 / R1: short period and set-equals-clear
        tag = "R6";
        stage(3, 5, 2, 2, 4, 1);
        mx = 0;
        repeat (20) begin @(negedge clk); if (cnt > mx) mx = cnt; end
        check(mx == 5, "R6 period 5 applied with set", mx, 5);
        tag = "R1";
        wait_cnt(5); @(negedge clk);
        check(cnt == 0, "R1 wrap to zero", cnt, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule